// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between a write-through cache and main memory. The processor hands it writes, each an address and a data word, and continues at once; the block queues them and later sends them to memory one at a time, oldest first. Reads pass through the same block. A read whose address matches a queued write is answered from the queue in one cycle, with no memory access. A read that misses goes to memory ahead of any queued write that has not yet started.

The memory side is a single port with a request/acknowledge handshake. The block holds a request with its address, direction and write data until memory acknowledges it. On the processor side, a read is held valid until the block pulses its done signal with the result. A write is taken on any cycle where write-ready is high.

Top module: `wbuf_bypass`

## Requirements
- R1: After a synchronous reset, cpu_wr_ready is 1, mem_req is 0 and cpu_rd_done is 0.
- R2: A write is accepted on a clock edge where cpu_wr_valid and cpu_wr_ready are both 1. cpu_wr_ready is 0 exactly while DEPTH (default 4) writes are held, and it returns to 1 after a queued write is acknowledged by memory.
- R3: Queued writes go to memory in the order they were accepted. Each is presented with mem_req=1 and mem_we=1, and its address and data stay stable until mem_ack. It leaves the queue on that acknowledge.
- R4: If no memory access is in progress, a pending read that misses the queue is issued to memory (mem_we=0) before any queued write.
- R5: A write access already presented to memory is not withdrawn. A missing read that arrives meanwhile waits for that acknowledge and is issued afterwards.
- R6: A read whose address matches a queued write raises cpu_rd_done one cycle after it is presented, with the queued data, and causes no memory read.
- R7: If several queued writes match a read address, the data comes from the one accepted most recently.
- R8: A read that misses drives mem_req=1, mem_we=0 and mem_addr equal to the read address. cpu_rd_done rises the cycle after mem_ack, and cpu_rd_data holds the mem_rdata sampled at that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_valid | input | 1 | Write request present |
| cpu_wr_ready | output | 1 | Queue can take a write |
| cpu_wr_addr | input | ADDR_W | Write address |
| cpu_wr_data | input | DATA_W | Write data |
| cpu_rd_valid | input | 1 | Read request, held until cpu_rd_done |
| cpu_rd_addr | input | ADDR_W | Read address |
| cpu_rd_done | output | 1 | One-cycle pulse: read data valid |
| cpu_rd_data | output | DATA_W | Read result |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory completes the current access |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
The assertions take the following as given:
- The processor keeps cpu_rd_valid and cpu_rd_addr steady until cpu_rd_done, and drops the request in the cycle that follows.
- Memory raises mem_ack only while mem_req is high, and for a single cycle per access.

The bench's read task releases cpu_rd_valid at the first falling edge after it sees done. Its memory model pulses acknowledge once per request after a set delay, or holds it back entirely while a stall flag is set. That stall is how the bench creates a full queue and a read that waits behind a write already in progress.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_RD   = 2'd1,
    ARB_WR   = 2'd2
  } arb_state_t;
endpackage

// File: rtl/wbuf_store.sv
// Circular queue of pending writes; all entries are visible for matching.
module wbuf_store #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              full,
  output logic              empty,
  output logic [PTR_W-1:0]  head_ptr,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic [ADDR_W-1:0] ent_addr [DEPTH],
  output logic [DATA_W-1:0] ent_data [DEPTH]
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  tail_q;
  logic [PTR_W-1:0]  head_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tail_q <= '0;
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign head_ptr  = head_q;
  assign count     = cnt_q;
  assign head_addr = addr_q[head_q];
  assign head_data = data_q[head_q];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      assign ent_addr[g] = addr_q[g];
      assign ent_data[g] = data_q[g];
    end
  endgenerate
endmodule

// File: rtl/wbuf_match.sv
// Scans live entries oldest to newest; the last hit seen wins (newest match).
module wbuf_match #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [PTR_W-1:0]  head_ptr,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] ent_addr [DEPTH],
  input  logic [DATA_W-1:0] ent_data [DEPTH],
  output logic              hit,
  output logic [DATA_W-1:0] hit_data
);
  logic [PTR_W-1:0] slot [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      assign slot[g] = head_ptr + PTR_W'(g);
    end
  endgenerate

  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if ((CNT_W'(k) < count) && (ent_addr[slot[k]] == rd_addr)) begin
        hit      = 1'b1;
        hit_data = ent_data[slot[k]];
      end
    end
  end
endmodule

// File: rtl/wbuf_arb.sv
// Memory port owner: reads before queued writes, requests held until ack.
module wbuf_arb
  import wbuf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              hit,
  input  logic [DATA_W-1:0] hit_data,
  input  logic              empty,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [DATA_W-1:0] head_data,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              pop
);
  arb_state_t state_q;
  logic       rd_pend;

  assign rd_pend = rd_valid && !rd_done;
  assign pop     = (state_q == ARB_WR) && mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ARB_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rd_done   <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_done <= 1'b0;
      case (state_q)
        ARB_IDLE: begin
          if (rd_pend && hit) begin
            rd_done <= 1'b1;
            rd_data <= hit_data;
          end else if (rd_pend) begin
            state_q  <= ARB_RD;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= rd_addr;
          end else if (!empty) begin
            state_q   <= ARB_WR;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= head_addr;
            mem_wdata <= head_data;
          end
        end
        ARB_RD: begin
          if (mem_ack) begin
            state_q <= ARB_IDLE;
            mem_req <= 1'b0;
            rd_done <= 1'b1;
            rd_data <= mem_rdata;
          end
        end
        ARB_WR: begin
          // hits are served while a drain is in flight; misses wait
          if (rd_pend && hit) begin
            rd_done <= 1'b1;
            rd_data <= hit_data;
          end
          if (mem_ack) begin
            state_q <= ARB_IDLE;
            mem_req <= 1'b0;
          end
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr_valid,
  output logic              cpu_wr_ready,
  input  logic [ADDR_W-1:0] cpu_wr_addr,
  input  logic [DATA_W-1:0] cpu_wr_data,
  input  logic              cpu_rd_valid,
  input  logic [ADDR_W-1:0] cpu_rd_addr,
  output logic              cpu_rd_done,
  output logic [DATA_W-1:0] cpu_rd_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              full, empty, push, pop, hit;
  logic [PTR_W-1:0]  head_ptr;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_data, hit_data;
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];

  assign cpu_wr_ready = !full;
  assign push         = cpu_wr_valid && !full;

  wbuf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst(rst), .push(push), .push_addr(cpu_wr_addr),
    .push_data(cpu_wr_data), .pop(pop), .full(full), .empty(empty),
    .head_ptr(head_ptr), .count(count), .head_addr(head_addr),
    .head_data(head_data), .ent_addr(ent_addr), .ent_data(ent_data)
  );

  wbuf_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) match_i (
    .rd_addr(cpu_rd_addr), .head_ptr(head_ptr), .count(count),
    .ent_addr(ent_addr), .ent_data(ent_data), .hit(hit), .hit_data(hit_data)
  );

  wbuf_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) arb_i (
    .clk(clk), .rst(rst), .rd_valid(cpu_rd_valid), .rd_addr(cpu_rd_addr),
    .hit(hit), .hit_data(hit_data), .empty(empty), .head_addr(head_addr),
    .head_data(head_data), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rd_done(cpu_rd_done), .rd_data(cpu_rd_data),
    .pop(pop)
  );
endmodule

// File: rtl/wbuf_bypass_chk.sv
module wbuf_bypass_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_wr_valid,
  input logic              cpu_wr_ready,
  input logic              cpu_rd_valid,
  input logic              cpu_rd_done,
  input logic [DATA_W-1:0] cpu_rd_data,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic [DATA_W-1:0] mem_rdata
);
  // occupancy seen from the ports: accepted writes minus acknowledged writes
  int occ;
  always_ff @(posedge clk) begin
    if (rst) occ <= 0;
    else occ <= occ + ((cpu_wr_valid && cpu_wr_ready) ? 1 : 0)
                    - ((mem_req && mem_we && mem_ack) ? 1 : 0);
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_req && !cpu_rd_done && cpu_wr_ready));

  // R2
  full_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_wr_ready == (occ != DEPTH));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                               && (!mem_we || $stable(mem_wdata))));

  // R4
  prio_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req) && mem_we) |-> !$past(cpu_rd_valid && !cpu_rd_done));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rd_done |=> !cpu_rd_done);

  // R8
  miss_return_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_ack) |=> (cpu_rd_done && cpu_rd_data == $past(mem_rdata)));
endmodule

bind wbuf_bypass wbuf_bypass_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .cpu_wr_valid(cpu_wr_valid), .cpu_wr_ready(cpu_wr_ready),
  .cpu_rd_valid(cpu_rd_valid), .cpu_rd_done(cpu_rd_done), .cpu_rd_data(cpu_rd_data),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .mem_rdata(mem_rdata)
);

// File: tb/wbuf_bypass_tb_top.sv
`timescale 1ns/1ps
module wbuf_bypass_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_wr_valid = 1'b0;
  logic          cpu_wr_ready;
  logic [AW-1:0] cpu_wr_addr = '0;
  logic [DW-1:0] cpu_wr_data = '0;
  logic          cpu_rd_valid = 1'b0;
  logic [AW-1:0] cpu_rd_addr = '0;
  logic          cpu_rd_done;
  logic [DW-1:0] cpu_rd_data;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wbuf_bypass #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4)) dut_i (
    .clk(clk), .rst(rst), .cpu_wr_valid(cpu_wr_valid), .cpu_wr_ready(cpu_wr_ready),
    .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
    .cpu_rd_valid(cpu_rd_valid), .cpu_rd_addr(cpu_rd_addr),
    .cpu_rd_done(cpu_rd_done), .cpu_rd_data(cpu_rd_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model with a service log
  logic [DW-1:0] bmem [256];
  logic          log_we   [16];
  logic [AW-1:0] log_addr [16];
  logic [DW-1:0] log_data [16];
  int log_n = 0;
  bit stall = 1'b1;
  int lat = 2;
  int wait_cnt = 0;

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 32'hC0DE_0000 + i;
  end

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack  = 1'b0;
      wait_cnt = 0;
    end else if (mem_req && !stall) begin
      if (wait_cnt >= lat) begin
        mem_ack   = 1'b1;
        mem_rdata = bmem[mem_addr[7:0]];
        if (mem_we) bmem[mem_addr[7:0]] = mem_wdata;
        if (log_n < 16) begin
          log_we[log_n]   = mem_we;
          log_addr[log_n] = mem_addr;
          log_data[log_n] = mem_wdata;
          log_n++;
        end
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!cpu_wr_ready) @(negedge clk);
    cpu_wr_valid = 1'b1;
    cpu_wr_addr  = a;
    cpu_wr_data  = d;
    @(negedge clk);
    cpu_wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                         output int cyc, output bit saw_mem);
    @(negedge clk);
    cpu_rd_valid = 1'b1;
    cpu_rd_addr  = a;
    cyc = 0;
    saw_mem = 1'b0;
    do begin
      @(negedge clk);
      cyc++;
      if (mem_req && !mem_we) saw_mem = 1'b1;
    end while (!cpu_rd_done);
    d = cpu_rd_data;
    cpu_rd_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(cpu_wr_ready == 1'b1, "R1 wr_ready", cpu_wr_ready, 1);
    chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
    chk(cpu_rd_done == 1'b0, "R1 rd_done", cpu_rd_done, 0);
  endtask

  task automatic t_hits();
    logic [DW-1:0] d;
    int cyc;
    bit sm;
    stall = 1'b1;
    push(16'h0010, 32'h1111_0001);
    push(16'h0020, 32'h2222_0002);
    push(16'h0010, 32'h1111_0003);
    do_read(16'h0010, d, cyc, sm);
    chk(d == 32'h1111_0003, "R7 newest match data", d, 32'h1111_0003);
    chk(cyc == 1, "R6 hit latency", cyc, 1);
    chk(!sm, "R6 hit no memory read", sm, 0);
    do_read(16'h0020, d, cyc, sm);
    chk(d == 32'h2222_0002, "R6 hit data", d, 32'h2222_0002);
    chk(cyc == 1 && !sm, "R6 second hit one cycle", cyc, 1);
  endtask

  task automatic t_full_and_priority();
    logic [DW-1:0] d;
    int cyc;
    bit sm;
    push(16'h0050, 32'h5555_0004);
    @(negedge clk);
    chk(cpu_wr_ready == 1'b0, "R2 ready low when four held", cpu_wr_ready, 0);
    chk(mem_req && mem_we && mem_addr == 16'h0010, "R3 head write presented", mem_addr, 16'h0010);
    chk(mem_wdata == 32'h1111_0001, "R3 head write data", mem_wdata, 32'h1111_0001);
    fork
      do_read(16'h0030, d, cyc, sm);
      begin
        repeat (6) @(negedge clk);
        chk(mem_req && mem_we && mem_addr == 16'h0010, "R5 write not withdrawn", mem_addr, 16'h0010);
        chk(!cpu_rd_done, "R5 read waits", cpu_rd_done, 0);
        lat = 2;
        stall = 1'b0;
      end
    join
    chk(d == 32'hC0DE_0030, "R8 miss data from memory", d, 32'hC0DE_0030);
    chk(sm, "R8 miss issued memory read", sm, 1);
    repeat (30) @(negedge clk);
    chk(cpu_wr_ready == 1'b1, "R2 ready back after drain", cpu_wr_ready, 1);
    chk(log_n == 5, "R3 service count", log_n, 5);
    chk(log_we[0] && log_addr[0] == 16'h0010 && log_data[0] == 32'h1111_0001,
        "R3 first drain", log_addr[0], 16'h0010);
    chk(!log_we[1] && log_addr[1] == 16'h0030, "R4 read before queued writes", log_addr[1], 16'h0030);
    chk(log_we[2] && log_addr[2] == 16'h0020 && log_data[2] == 32'h2222_0002,
        "R3 second drain", log_data[2], 32'h2222_0002);
    chk(log_we[3] && log_addr[3] == 16'h0010 && log_data[3] == 32'h1111_0003,
        "R3 third drain", log_data[3], 32'h1111_0003);
    chk(log_we[4] && log_addr[4] == 16'h0050 && log_data[4] == 32'h5555_0004,
        "R3 fourth drain", log_data[4], 32'h5555_0004);
    chk(bmem[8'h10] == 32'h1111_0003, "R3 final memory value", bmem[8'h10], 32'h1111_0003);
  endtask

  task automatic t_miss();
    logic [DW-1:0] d;
    int cyc;
    bit sm;
    do_read(16'h0044, d, cyc, sm);
    chk(d == 32'hC0DE_0044, "R8 empty-queue miss data", d, 32'hC0DE_0044);
    chk(sm && cyc > 1, "R8 empty-queue miss uses memory", cyc, 2);
    do_read(16'h0020, d, cyc, sm);
    chk(d == 32'h2222_0002 && sm, "R8 read of drained write", d, 32'h2222_0002);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_hits();
    t_full_and_priority();
    t_miss();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule